// File: doc/BRIEF.md
# Two-Source Vector Lane Selector

This block forms one output vector of eight 16-bit lanes. Each lane is taken from a pool of sixteen 16-bit elements, which is the two 128-bit source vectors placed side by side. Every output lane has its own 4-bit index. The same hardware can therefore produce a straight copy, a rotation, a lane shift with fill from the second source, an interleave of the two sources, or a broadcast. The index is the only thing that changes from one pattern to the next.

A request strobe presents both sources and a packed 32-bit selection word. The permuted vector is captured in an output register, and a valid strobe is raised in the following cycle. Between requests, the output register holds the last result. The block contains no register file and no arithmetic.

Top module: `vec_lane_selector`

## Requirements
- R1: While reset is asserted, and until the first accepted request, `res_vld_o` is 0 and `res_vec_o` is all zeros.
- R2: Output lane k takes element i of the pool. For i in 0..7 the element is lane i of source A. For i in 8..15 it is lane i-8 of source B.
- R3: The index for output lane k is `sel_i[4k+3:4k]`.
- R4: `res_vld_o` is 1 in the cycle after a clock edge at which `req_i` was 1. It is 0 in the cycle after an edge at which `req_i` was 0.
- R5: If `req_i` is 0 at a clock edge, `res_vec_o` keeps its value, whatever the source and selection inputs do.
- R6: Lane 0 of every vector is bits 15:0, and lane k is bits 16k+15:16k.
- R7: Two or more output lanes may carry the same index. Each of them then receives a copy of that element.
- R8: Requests on consecutive cycles each produce their own result, one cycle later, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Request strobe; the inputs are sampled when it is 1 |
| src_a_i | input | 128 | Source A, pool elements 0..7 |
| src_b_i | input | 128 | Source B, pool elements 8..15 |
| sel_i | input | 32 | Packed lane indices, 4 bits per output lane |
| res_vld_o | output | 1 | High for one cycle per accepted request |
| res_vec_o | output | 128 | Permuted result, held between requests |

## Verification
Random selection words almost never repeat an index across many lanes. They also almost never form the exact patterns that show a lane or field ordering error, such as a rotate by one or an A/B interleave. The stimulus therefore mixes directed selection words with the random ones: identity, all-from-B, rotate, shift with fill from B, interleave, and full broadcast of element 0 and of element 15. Random requests with random gaps follow these. The gaps test the hold behaviour while the inputs keep changing, and the back-to-back runs test that consecutive results are not mixed up.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  // Default geometry of the selector
  localparam int unsigned VSEL_LANE_W = 16;
  localparam int unsigned VSEL_LANES  = 8;

  // Width needed to name one element of a pool holding n elements
  function automatic int unsigned idx_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/vsel_rst_sync.sv
module vsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stg1_q;
  logic stg1_d;
  logic stg2_q;
  logic stg2_d;

  always_comb begin
    stg1_d = 1'b1;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign rst_q_n = stg2_q;
endmodule

// File: rtl/vsel_lane_mux.sv
module vsel_lane_mux #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned POOL_N = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [POOL_N*LANE_W-1:0] pool_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [LANE_W-1:0]        lane_o
);
  // AND-OR mux: one decoded hit per pool element
  logic [POOL_N-1:0] hit;

  always_comb begin
    for (int e = 0; e < POOL_N; e++) begin
      hit[e] = (idx_i == IDX_W'(e));
    end
  end

  always_comb begin
    lane_o = '0;
    for (int e = 0; e < POOL_N; e++) begin
      lane_o = lane_o | ({LANE_W{hit[e]}} & pool_i[e*LANE_W +: LANE_W]);
    end
  end
endmodule

// File: rtl/vsel_out_reg.sv
module vsel_out_reg #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             vld_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             vld_q;
  logic             vld_d;
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    vld_d = load_i;
    vec_d = vec_q;
    if (load_i) vec_d = vec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= vld_d;
      vec_q <= vec_d;
    end
  end

  assign vld_o = vld_q;
  assign vec_o = vec_q;

  // R4
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> vld_o);
  // R4
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> !vld_o);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(vec_o));
  // R8
  b2b_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (vec_o == $past(vec_i)));
endmodule

// File: rtl/vec_lane_selector.sv
module vec_lane_selector
  import vsel_pkg::*;
#(
  parameter int unsigned LANE_W = VSEL_LANE_W,
  parameter int unsigned LANES  = VSEL_LANES
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        req_i,
  input  logic [LANES*LANE_W-1:0]                     src_a_i,
  input  logic [LANES*LANE_W-1:0]                     src_b_i,
  input  logic [LANES*idx_width(2*LANES)-1:0]         sel_i,
  output logic                                        res_vld_o,
  output logic [LANES*LANE_W-1:0]                     res_vec_o
);
  localparam int unsigned POOL_N = 2 * LANES;
  localparam int unsigned IDX_W  = idx_width(POOL_N);
  localparam int unsigned VEC_W  = LANES * LANE_W;

  logic                   rst_q_n;
  logic [POOL_N*LANE_W-1:0] pool;
  logic [VEC_W-1:0]         perm_vec;

  vsel_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  // Source A occupies the low half of the pool, source B the high half
  assign pool = {src_b_i, src_a_i};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vsel_lane_mux #(
      .LANE_W(LANE_W),
      .POOL_N(POOL_N),
      .IDX_W (IDX_W)
    ) u_mux (
      .pool_i(pool),
      .idx_i (sel_i[k*IDX_W +: IDX_W]),
      .lane_o(perm_vec[k*LANE_W +: LANE_W])
    );
  end

  vsel_out_reg #(
    .VEC_W(VEC_W)
  ) u_out (
    .clk   (clk),
    .rst_n (rst_q_n),
    .load_i(req_i),
    .vec_i (perm_vec),
    .vld_o (res_vld_o),
    .vec_o (res_vec_o)
  );

  // R2 R6
  lane0_from_a_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_i && sel_i[IDX_W-1:0] == '0)
      |=> (res_vec_o[LANE_W-1:0] == $past(src_a_i[LANE_W-1:0])));
  // R2 R6
  lane0_from_b_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_i && sel_i[IDX_W-1:0] == IDX_W'(LANES))
      |=> (res_vec_o[LANE_W-1:0] == $past(src_b_i[LANE_W-1:0])));
  // R3
  top_lane_from_b_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_i && sel_i[(LANES-1)*IDX_W +: IDX_W] == IDX_W'(POOL_N-1))
      |=> (res_vec_o[VEC_W-1 -: LANE_W] == $past(src_b_i[VEC_W-1 -: LANE_W])));
endmodule

// File: tb/sim_vec_lane_selector.sv
module sim_vec_lane_selector;
  logic         clk;
  logic         rst_n;
  logic         req_i;
  logic [127:0] src_a_i;
  logic [127:0] src_b_i;
  logic [31:0]  sel_i;
  logic         res_vld_o;
  logic [127:0] res_vec_o;

  int n_tests;
  int n_fail;
  int seed;

  vec_lane_selector u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .sel_i    (sel_i),
    .res_vld_o(res_vld_o),
    .res_vec_o(res_vec_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected permutation from R2/R3/R6
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [31:0] s);
    logic [127:0] r;
    logic [255:0] p;
    p = {b, a};
    for (int k = 0; k < 8; k++) begin
      r[k*16 +: 16] = p[s[k*4 +: 4]*16 +: 16];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Issue one request at a negedge; result checked one negedge later
  task automatic one_req(input string req, input logic [31:0] s);
    logic [127:0] a;
    logic [127:0] b;
    a = rnd128();
    b = rnd128();
    @(negedge clk);
    req_i = 1'b1; src_a_i = a; src_b_i = b; sel_i = s;
    @(negedge clk);
    req_i = 1'b0;
    check({req, " vld"}, {127'd0, res_vld_o}, 128'd1);
    check(req, res_vec_o, model(a, b, s));
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [127:0] held;
    logic [127:0] pa, pb;
    logic [31:0]  ps;
    n_tests = 0; n_fail = 0;
    seed = $urandom(32'h5eed_1234);
    rst_n = 1'b1; req_i = 1'b0; src_a_i = '0; src_b_i = '0; sel_i = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset, with a request pending
    req_i = 1'b1; src_a_i = rnd128(); sel_i = 32'h7654_3210;
    @(negedge clk);
    check("R1 reset vld", {127'd0, res_vld_o}, 128'd0);
    check("R1 reset vec", res_vec_o, 128'd0);
    req_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release vld", {127'd0, res_vld_o}, 128'd0);
    check("R1 after release vec", res_vec_o, 128'd0);

    // Directed patterns
    one_req("R2 identity copy A", 32'h7654_3210);
    one_req("R2 all from B", 32'hFEDC_BA98);
    one_req("R3 rotate by one", 32'h0765_4321);
    one_req("R3 shift fill from B", 32'h8765_4321);
    one_req("R2 interleave A/B", 32'hB3A2_9180);
    one_req("R7 broadcast elem 0", 32'h0000_0000);
    one_req("R7 broadcast elem 15", 32'hFFFF_FFFF);
    one_req("R6 lane 0 only B elem 8", 32'h7654_3218);
    one_req("R3 reverse", 32'h0123_4567);

    // R5: hold while inputs wander without a request
    held = res_vec_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      src_a_i = rnd128(); src_b_i = rnd128(); sel_i = $urandom;
      @(negedge clk);
      check("R5 hold vec", res_vec_o, held);
      check("R4 idle vld", {127'd0, res_vld_o}, 128'd0);
    end

    // R8: back-to-back random requests, with random gaps
    @(negedge clk);
    pa = rnd128(); pb = rnd128(); ps = $urandom;
    req_i = 1'b1; src_a_i = pa; src_b_i = pb; sel_i = ps;
    for (int i = 0; i < 300; i++) begin
      logic         nreq;
      logic [127:0] na, nb;
      logic [31:0]  ns;
      logic [127:0] exp;
      logic         exp_vld;
      exp_vld = req_i;
      exp = exp_vld ? model(pa, pb, ps) : res_vec_o;
      nreq = ($urandom % 4) != 0;
      na = rnd128(); nb = rnd128(); ns = $urandom;
      @(negedge clk);
      check("R8 stream vec", res_vec_o, exp);
      check("R4 stream vld", {127'd0, res_vld_o}, {127'd0, exp_vld});
      req_i = nreq; src_a_i = na; src_b_i = nb; sel_i = ns;
      pa = na; pb = nb; ps = ns;
    end
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule